// File: doc/BRIEF.md
# Proximity Measurement Cycle Sequencer

This block is the power and measurement controller of a pulsed-infrared proximity sensor. It rests in a low-power Sleep phase until the host bus reports a start condition. It then waits in Idle until both the power-on and the proximity-enable controls are set. From there it runs a fixed order of phases: settle, LED pulse accumulation, a second settle, and conversion. An optional Wait phase follows, and the block then returns to Idle and starts again on its own.

All phase lengths come from a microsecond tick supplied from outside, counted by a parameterised amount. A short step can therefore replace the nominal 2.73 ms step in simulation. The conversion and wait lengths are given as two's-complement step counts, so a register value of r means 256 − r steps. Long-wait mode stretches each wait step twelve-fold. During accumulation the block drives the LED current sink enable with a programmable number of pulses. It raises one-cycle strobes for conversion start, result ready and end of cycle. It can drop back to Sleep when an interrupt is pending at the end of a conversion.

Top module: `prox_cycle_seq`

## Requirements
- R1: After synchronous reset the phase output is Sleep (code 0), and led_on, adc_start, result_ready, cycle_done and data_valid are all low.
- R2: In Sleep (0), a bus_start pulse moves the block to Idle (1) on the next clock. In Idle, power-on low sends it back to Sleep on the next clock. With power-on high and proximity-enable low it stays in Idle.
- R3: With power-on and proximity-enable high, Idle leads to Init (2), then Accum (3), then Settle (4), then Convert (5). After that comes Wait (6) if wait_en is high, then Idle, and then a new Init.
- R4: Init and Settle each last exactly one step of TICKS_PER_STEP ticks.
- R5: Accum lasts pulse_count × PULSE_PERIOD ticks. In each period led_on is high for the first PULSE_ON ticks. With pulse_count 0, Accum lasts one cycle and the LED never lights. integ_en is high in exactly the Accum cycles.
- R6: Convert lasts 256 − ptime steps. adc_start is high for only the first Convert cycle.
- R7: Wait lasts 256 − wtime steps. With long_wait high, each step is LONG_MULT (12) times TICKS_PER_STEP ticks.
- R8: If irq_active and sleep_after_irq are both high when Convert ends, the block enters Sleep and stays there until bus_start.
- R9: data_valid rises together with the first result_ready and drops the clock after prox_en is seen low.
- R10: With power-on low, led_on is low in the same cycle, and any phase other than Sleep becomes Sleep on the next clock.
- R11: result_ready is a one-cycle pulse in the first cycle after Convert ends. cycle_done is a one-cycle pulse in the first Idle cycle after Convert or Wait.
- R12: Timed phases advance only on cycles with tick_us high. Without ticks, the phase holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | Microsecond timebase tick, one clock wide |
| bus_start | input | 1 | Host bus start condition detected |
| pwr_on | input | 1 | Power-on control |
| prox_en | input | 1 | Proximity measurement enable |
| wait_en | input | 1 | Enables the Wait phase after conversion |
| long_wait | input | 1 | Stretches wait steps by LONG_MULT |
| sleep_after_irq | input | 1 | Sleep when an interrupt is pending at conversion end |
| irq_active | input | 1 | Interrupt pending, from the threshold logic |
| pulse_count | input | 8 | LED pulses per accumulation (0..255) |
| ptime | input | 8 | Conversion length, 256 − ptime steps |
| wtime | input | 8 | Wait length, 256 − wtime steps |
| led_on | output | 1 | LED current sink enable |
| integ_en | output | 1 | Integrator enable during accumulation |
| adc_start | output | 1 | One-cycle strobe at conversion start |
| result_ready | output | 1 | One-cycle strobe after conversion end |
| cycle_done | output | 1 | One-cycle strobe when a cycle returns to Idle |
| data_valid | output | 1 | A result has been produced since proximity was enabled |
| phase_o | output | 3 | Current phase code (0 Sleep, 1 Idle, 2 Init, 3 Accum, 4 Settle, 5 Convert, 6 Wait) |

## Verification
A wrong phase register shows on phase_o at the next sample, because every phase is exported directly. A wrong step or pulse counter shows only when a phase ends, and it ends early or late by whole ticks. The bench therefore times every phase of every cycle in clock counts and also counts LED-on cycles. A slip in the strobe or valid logic shows within one clock of the Convert exit, where result_ready, data_valid and cycle_done are sampled. Corner values of the step registers (0x00, 0xFF), zero pulses, long wait, a starved tick and mid-cycle power loss are each run directly.

// File: rtl/prox_seq_pkg.sv
// Shared definitions for the proximity cycle sequencer.
// Assumes: phase codes are visible at the top port and decoded by the bench.
package prox_seq_pkg;

    typedef enum logic [2:0] {
        PH_SLEEP  = 3'd0,
        PH_IDLE   = 3'd1,
        PH_INIT   = 3'd2,
        PH_ACCUM  = 3'd3,
        PH_SETTLE = 3'd4,
        PH_CONV   = 3'd5,
        PH_WAIT   = 3'd6
    } phase_e;

    // Two's-complement step register: value r gives 256 - r steps (1..256).
    function automatic logic [8:0] steps_from_reg(input logic [7:0] r);
        return 9'd256 - {1'b0, r};
    endfunction

endpackage

// File: rtl/prox_step_timer.sv
// Step timer for the timed phases.
// Counts tick_us pulses into steps of TICKS_PER_STEP ticks, or of
// TICKS_PER_STEP*LONG_MULT ticks when long_step is high. It reports done on
// the final tick of the final step.
// Assumes: restart is high in the cycle before a new phase begins;
// num_steps is at least 1.
module prox_step_timer #(
    parameter int TICKS_PER_STEP = 2730,
    parameter int LONG_MULT      = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic       tick,
    input  logic       long_step,
    input  logic [8:0] num_steps,
    output logic       done
);
    localparam int LONG_TICKS = TICKS_PER_STEP * LONG_MULT;
    localparam int TW         = $clog2(LONG_TICKS + 1);

    logic [TW-1:0] tick_cnt;
    logic [8:0]    step_cnt;
    logic [TW-1:0] step_limit;
    logic          last_tick;
    logic          last_step;

    // Select the last tick index of a step.
    always_comb begin
        step_limit = long_step ? TW'(LONG_TICKS - 1) : TW'(TICKS_PER_STEP - 1);
        last_tick  = (tick_cnt == step_limit);
        last_step  = (step_cnt == (num_steps - 9'd1));
        done       = run && tick && last_tick && last_step;
    end

    // Advance the tick and step counters; clear them at each phase change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tick_cnt <= '0;
            step_cnt <= '0;
        end else if (run && tick) begin
            if (last_tick) begin
                tick_cnt <= '0;
                step_cnt <= step_cnt + 9'd1;
            end else begin
                tick_cnt <= tick_cnt + TW'(1);
            end
        end
    end

endmodule

// File: rtl/prox_pulse_train.sv
// LED pulse train generator for the accumulation phase.
// Emits pulse_count periods of PULSE_PERIOD ticks, with the LED high for the
// first PULSE_ON ticks of each. A zero count finishes at once without light.
// Assumes: PULSE_ON < PULSE_PERIOD; restart precedes each accumulation.
module prox_pulse_train #(
    parameter int PULSE_PERIOD = 16,
    parameter int PULSE_ON     = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic       tick,
    input  logic       light_ok,
    input  logic [7:0] pulse_count,
    output logic       led,
    output logic       done
);
    localparam int PW = $clog2(PULSE_PERIOD + 1);

    logic [PW-1:0] ptick;
    logic [7:0]    pnum;
    logic          none;
    logic          period_end;

    // Decode the pulse position, LED level and end of accumulation.
    always_comb begin
        none       = (pulse_count == 8'd0);
        period_end = tick && (ptick == PW'(PULSE_PERIOD - 1));
        led        = run && light_ok && !none && (ptick < PW'(PULSE_ON));
        done       = run && (none || (period_end && (pnum == pulse_count - 8'd1)));
    end

    // Step through the position in a period and the count of pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ptick <= '0;
            pnum  <= '0;
        end else if (run && tick && !none) begin
            if (period_end) begin
                ptick <= '0;
                pnum  <= pnum + 8'd1;
            end else begin
                ptick <= ptick + PW'(1);
            end
        end
    end

endmodule

// File: rtl/prox_seq_fsm.sv
// Phase controller of the proximity sequencer.
// Holds the phase register, chooses the next phase from the enables and the
// done flags of the timers, and registers the strobes and the valid flag.
// Assumes: tim_done and acc_done are combinational from the current phase.
module prox_seq_fsm
    import prox_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bus_start,
    input  logic   pwr_on,
    input  logic   prox_en,
    input  logic   wait_en,
    input  logic   sleep_after_irq,
    input  logic   irq_active,
    input  logic   tim_done,
    input  logic   acc_done,
    output phase_e phase_q,
    output logic   restart,
    output logic   adc_start_q,
    output logic   result_ready_q,
    output logic   cycle_done_q,
    output logic   data_valid_q
);
    phase_e state_d;
    logic   conv_end;

    // Next-phase selection; power-off overrides every phase except Sleep.
    always_comb begin
        state_d = phase_q;
        if (!pwr_on && phase_q != PH_SLEEP) begin
            state_d = PH_SLEEP;
        end else begin
            unique case (phase_q)
                PH_SLEEP:  if (bus_start) state_d = PH_IDLE;
                PH_IDLE:   if (prox_en) state_d = PH_INIT;
                PH_INIT:   if (tim_done) state_d = PH_ACCUM;
                PH_ACCUM:  if (acc_done) state_d = PH_SETTLE;
                PH_SETTLE: if (tim_done) state_d = PH_CONV;
                PH_CONV: begin
                    if (tim_done) begin
                        if (irq_active && sleep_after_irq) state_d = PH_SLEEP;
                        else if (wait_en)                  state_d = PH_WAIT;
                        else                               state_d = PH_IDLE;
                    end
                end
                PH_WAIT:   if (tim_done) state_d = PH_IDLE;
                default:   state_d = PH_SLEEP;
            endcase
        end
        restart  = (state_d != phase_q);
        conv_end = (phase_q == PH_CONV) && tim_done && pwr_on;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_SLEEP;
        else        phase_q <= state_d;
    end

    // One-cycle strobes, aligned with the first cycle of the following phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_start_q    <= 1'b0;
            result_ready_q <= 1'b0;
            cycle_done_q   <= 1'b0;
        end else begin
            adc_start_q    <= (state_d == PH_CONV) && (phase_q != PH_CONV);
            result_ready_q <= conv_end;
            cycle_done_q   <= (state_d == PH_IDLE) &&
                              ((phase_q == PH_CONV) || (phase_q == PH_WAIT));
        end
    end

    // Valid flag: set by a finished conversion, cleared while proximity is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !prox_en) data_valid_q <= 1'b0;
        else if (conv_end)      data_valid_q <= 1'b1;
    end

endmodule

// File: rtl/prox_cycle_seq.sv
// Top of the proximity measurement cycle sequencer.
// Joins the phase controller, one shared step timer for the timed phases and
// the LED pulse train. It selects the step count and step length per phase.
// Assumes: tick_us is a single-clock pulse from an external timebase.
module prox_cycle_seq
    import prox_seq_pkg::*;
#(
    parameter int TICKS_PER_STEP = 2730,
    parameter int LONG_MULT      = 12,
    parameter int PULSE_PERIOD   = 16,
    parameter int PULSE_ON       = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       bus_start,
    input  logic       pwr_on,
    input  logic       prox_en,
    input  logic       wait_en,
    input  logic       long_wait,
    input  logic       sleep_after_irq,
    input  logic       irq_active,
    input  logic [7:0] pulse_count,
    input  logic [7:0] ptime,
    input  logic [7:0] wtime,
    output logic       led_on,
    output logic       integ_en,
    output logic       adc_start,
    output logic       result_ready,
    output logic       cycle_done,
    output logic       data_valid,
    output logic [2:0] phase_o
);
    phase_e     phase_q;
    logic       restart;
    logic       tim_done;
    logic       acc_done;
    logic       tim_run;
    logic       acc_run;
    logic       long_step;
    logic [8:0] num_steps;

    // Step count and step length for the current timed phase.
    always_comb begin
        tim_run   = 1'b1;
        long_step = 1'b0;
        num_steps = 9'd1;
        unique case (phase_q)
            PH_INIT, PH_SETTLE: num_steps = 9'd1;
            PH_CONV:            num_steps = steps_from_reg(ptime);
            PH_WAIT: begin
                num_steps = steps_from_reg(wtime);
                long_step = long_wait;
            end
            default:            tim_run = 1'b0;
        endcase
        acc_run  = (phase_q == PH_ACCUM);
        integ_en = acc_run && pwr_on;
        phase_o  = phase_q;
    end

    prox_seq_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_start       (bus_start),
        .pwr_on          (pwr_on),
        .prox_en         (prox_en),
        .wait_en         (wait_en),
        .sleep_after_irq (sleep_after_irq),
        .irq_active      (irq_active),
        .tim_done        (tim_done),
        .acc_done        (acc_done),
        .phase_q         (phase_q),
        .restart         (restart),
        .adc_start_q     (adc_start),
        .result_ready_q  (result_ready),
        .cycle_done_q    (cycle_done),
        .data_valid_q    (data_valid)
    );

    prox_step_timer #(
        .TICKS_PER_STEP (TICKS_PER_STEP),
        .LONG_MULT      (LONG_MULT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .run       (tim_run),
        .tick      (tick_us),
        .long_step (long_step),
        .num_steps (num_steps),
        .done      (tim_done)
    );

    prox_pulse_train #(
        .PULSE_PERIOD (PULSE_PERIOD),
        .PULSE_ON     (PULSE_ON)
    ) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .run         (acc_run),
        .tick        (tick_us),
        .light_ok    (pwr_on),
        .pulse_count (pulse_count),
        .led         (led_on),
        .done        (acc_done)
    );

endmodule

// File: rtl/prox_cycle_seq_chk.sv
// Property checker for the proximity sequencer, bound to the top module.
// Observes ports only.
module prox_cycle_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_us,
    input logic       pwr_on,
    input logic       led_on,
    input logic       integ_en,
    input logic       adc_start,
    input logic       result_ready,
    input logic       cycle_done,
    input logic       data_valid,
    input logic [2:0] phase_o
);
    // R10: no light while power is off.
    a_r10_led_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> !led_on);

    // R10: power-off leaves any awake phase for Sleep on the next clock.
    a_r10_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_on && phase_o != 3'd0) |=> (phase_o == 3'd0));

    // R5: LED and integrator are active only in Accum.
    a_r5_led_in_accum: assert property (@(posedge clk) disable iff (!rst_n)
        (led_on || integ_en) |-> (phase_o == 3'd3));

    // R6: the conversion-start strobe appears only in Convert and lasts one cycle.
    a_r6_adc_start: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (phase_o == 3'd5) ##1 !adc_start);

    // R11: result and cycle strobes are single-cycle pulses.
    a_r11_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_ready |=> !result_ready);
    a_r11_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (phase_o == 3'd1) ##1 !cycle_done);

    // R3: Init leads only to Accum, or to Sleep on power loss.
    a_r3_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd2) |=> (phase_o inside {3'd2, 3'd3, 3'd0}));

    // R9: data_valid rises only together with a result strobe.
    a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> result_ready);

    // R12: without a tick, timed phases hold.
    a_r12_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_us && pwr_on && (phase_o inside {3'd2, 3'd4, 3'd5, 3'd6}))
        |=> $stable(phase_o));

endmodule

bind prox_cycle_seq prox_cycle_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_us      (tick_us),
    .pwr_on       (pwr_on),
    .led_on       (led_on),
    .integ_en     (integ_en),
    .adc_start    (adc_start),
    .result_ready (result_ready),
    .cycle_done   (cycle_done),
    .data_valid   (data_valid),
    .phase_o      (phase_o)
);

// File: tb/prox_cycle_seq_tb_top.sv
// Self-checking bench for the proximity sequencer: directed corners plus
// seeded random cycles, with every phase timed in clocks against bench math.
module prox_cycle_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TPS = 4;
    localparam int LM  = 12;
    localparam int PER = 16;
    localparam int ON  = 7;

    localparam logic [2:0] SLEEP = 3'd0, IDLE = 3'd1, INIT = 3'd2, ACCUM = 3'd3,
                           SETTLE = 3'd4, CONV = 3'd5, WAITP = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b1;
    logic bus_start = 1'b0, pwr_on = 1'b0, prox_en = 1'b0, wait_en = 1'b0;
    logic long_wait = 1'b0, sleep_after_irq = 1'b0, irq_active = 1'b0;
    logic [7:0] pulse_count = 8'd0, ptime = 8'hFF, wtime = 8'hFF;
    logic led_on, integ_en, adc_start, result_ready, cycle_done, data_valid;
    logic [2:0] phase_o;

    int tests = 0;
    int fails = 0;
    int slow = 1;
    int cyc = 0;
    bit finished = 1'b0;

    prox_cycle_seq #(
        .TICKS_PER_STEP (TPS), .LONG_MULT (LM),
        .PULSE_PERIOD (PER), .PULSE_ON (ON)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .tick_us (tick_us), .bus_start (bus_start),
        .pwr_on (pwr_on), .prox_en (prox_en), .wait_en (wait_en),
        .long_wait (long_wait), .sleep_after_irq (sleep_after_irq),
        .irq_active (irq_active), .pulse_count (pulse_count), .ptime (ptime),
        .wtime (wtime), .led_on (led_on), .integ_en (integ_en),
        .adc_start (adc_start), .result_ready (result_ready),
        .cycle_done (cycle_done), .data_valid (data_valid), .phase_o (phase_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Timebase: every cycle, or every other cycle in slow mode.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        tick_us <= (slow == 1) ? 1'b1 : ((cyc % 2) == 0);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Duration check; in slow mode the phase may start on a tickless cycle.
    task automatic chk_dur(input string req, input string what, input int act,
                           input int ticks);
        int exp = ticks * slow;
        chk((act == exp) || (slow > 1 && act == exp - 1), req, what, act, exp);
    endtask

    task automatic count_phase(input logic [2:0] ph, output int n,
                               output int leds, output int integ);
        n = 0; leds = 0; integ = 0;
        while (phase_o == ph && n < 40000) begin
            n++;
            if (led_on) leds++;
            if (integ_en) integ++;
            @(negedge clk);
        end
    endtask

    task automatic wait_phase(input logic [2:0] ph);
        for (int i = 0; i < 40000 && phase_o != ph; i++) @(negedge clk);
    endtask

    task automatic pulse_bus();
        bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
    endtask

    // One full measurement cycle from Idle with proximity off, timed phase by phase.
    task automatic run_cycle(input int p, input int pt, input int wt,
                             input bit we, input bit lw);
        int n, l, g, wticks;
        pulse_count = 8'(p); ptime = 8'(pt); wtime = 8'(wt);
        wait_en = we; long_wait = lw; prox_en = 1'b1;
        @(negedge clk);
        chk(phase_o == INIT, "R3", "enter init", phase_o, INIT);
        count_phase(INIT, n, l, g);
        chk_dur("R4", "init length", n, TPS);
        chk(phase_o == ACCUM, "R3", "enter accum", phase_o, ACCUM);
        count_phase(ACCUM, n, l, g);
        if (p == 0) chk(n == 1, "R5", "zero-pulse accum", n, 1);
        else        chk_dur("R5", "accum length", n, p * PER);
        if (slow == 1) chk(l == p * ON, "R5", "led cycles", l, p * ON);
        chk(g == n, "R5", "integ cycles", g, n);
        chk(phase_o == SETTLE, "R3", "enter settle", phase_o, SETTLE);
        count_phase(SETTLE, n, l, g);
        chk_dur("R4", "settle length", n, TPS);
        chk(phase_o == CONV, "R3", "enter convert", phase_o, CONV);
        chk(adc_start == 1'b1, "R6", "adc_start first cycle", adc_start, 1);
        count_phase(CONV, n, l, g);
        chk_dur("R6", "convert length", n, (256 - pt) * TPS);
        chk(result_ready == 1'b1, "R11", "result_ready", result_ready, 1);
        chk(data_valid == 1'b1, "R9", "data_valid set", data_valid, 1);
        if (we) begin
            chk(phase_o == WAITP, "R3", "enter wait", phase_o, WAITP);
            count_phase(WAITP, n, l, g);
            wticks = (256 - wt) * TPS * (lw ? LM : 1);
            chk_dur("R7", "wait length", n, wticks);
        end
        chk(phase_o == IDLE, "R3", "back to idle", phase_o, IDLE);
        chk(cycle_done == 1'b1, "R11", "cycle_done", cycle_done, 1);
        prox_en = 1'b0;
        @(negedge clk);
        chk(data_valid == 1'b0, "R9", "data_valid cleared", data_valid, 0);
        chk(phase_o == IDLE, "R2", "idle holds without enable", phase_o, IDLE);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(phase_o == SLEEP, "R1", "reset phase", phase_o, SLEEP);
        chk(!led_on && !adc_start && !result_ready && !cycle_done && !data_valid,
            "R1", "reset outputs", led_on, 0);

        // R2: wake with power off falls back to Sleep.
        pulse_bus();
        chk(phase_o == IDLE, "R2", "wake to idle", phase_o, IDLE);
        @(negedge clk);
        chk(phase_o == SLEEP, "R2", "no power back to sleep", phase_o, SLEEP);
        pwr_on = 1'b1;
        repeat (5) @(negedge clk);
        chk(phase_o == SLEEP, "R2", "sleep without bus start", phase_o, SLEEP);
        pulse_bus();
        repeat (5) @(negedge clk);
        chk(phase_o == IDLE, "R2", "idle with proximity off", phase_o, IDLE);

        // Directed corners.
        run_cycle(1, 8'hFF, 8'hFF, 1'b0, 1'b0);
        run_cycle(0, 8'hFE, 8'hFF, 1'b1, 1'b0);
        run_cycle(8, 8'h00, 8'hFC, 1'b1, 1'b0);
        run_cycle(255, 8'hFF, 8'hFF, 1'b0, 1'b0);
        run_cycle(2, 8'hFF, 8'h00, 1'b1, 1'b1);
        run_cycle(1, 8'hFF, 8'hFD, 1'b1, 1'b1);
        // R12: starved tick stretches every phase.
        slow = 2;
        @(negedge clk);
        run_cycle(3, 8'hFD, 8'hFB, 1'b1, 1'b0);
        slow = 1;
        @(negedge clk);
        // Random cycles.
        for (int k = 0; k < 8; k++) begin
            int p  = $urandom_range(0, 6);
            int pt = $urandom_range(236, 255);
            int wt = $urandom_range(240, 255);
            bit we = 1'($urandom_range(0, 1));
            bit lw = 1'($urandom_range(0, 1));
            run_cycle(p, pt, wt, we, lw);
        end

        // R8: interrupt with sleep-after-interrupt ends in Sleep.
        irq_active = 1'b1; sleep_after_irq = 1'b1; wait_en = 1'b1;
        pulse_count = 8'd2; ptime = 8'hFF; prox_en = 1'b1;
        wait_phase(CONV);
        while (phase_o == CONV) @(negedge clk);
        chk(phase_o == SLEEP, "R8", "sleep after irq", phase_o, SLEEP);
        chk(result_ready == 1'b1, "R11", "result before sleep", result_ready, 1);
        repeat (30) @(negedge clk);
        chk(phase_o == SLEEP, "R8", "stays asleep", phase_o, SLEEP);
        irq_active = 1'b0;
        pulse_bus();
        chk(phase_o == IDLE, "R8", "bus start wakes", phase_o, IDLE);
        @(negedge clk);
        chk(phase_o == INIT, "R3", "restart cycle", phase_o, INIT);

        // R10: power loss mid-accumulation.
        wait_phase(ACCUM);
        @(negedge clk); @(negedge clk);
        chk(led_on == 1'b1, "R5", "led lit in pulse", led_on, 1);
        pwr_on = 1'b0;
        #1;
        chk(led_on == 1'b0, "R10", "led dark at power off", led_on, 0);
        @(negedge clk);
        chk(phase_o == SLEEP, "R10", "abort to sleep", phase_o, SLEEP);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule